// File: doc/BRIEF.md
# Dual-Request Data Cache Pairing Arbiter

This block sits in front of a data cache whose arrays can take two accesses in one cycle, but only for certain pairs. Two request ports each offer an address, a size code, a write flag and a valid bit, with a ready returned per port. Each cycle the arbiter decides whether both offered requests may go to the cache together. If they may not, it grants one and stalls the other through its ready signal.

Legality depends on the kind of pair. Two reads of up to eight bytes always pair. A mixed read/write pair, or two eight-byte writes, must fall inside one aligned 16-byte block. Two writes narrower than eight bytes must share one aligned 8-byte block and touch disjoint bytes. When a pair is refused, the older request wins. A request that was stalled becomes the older one on the next cycle, so neither port can starve.

A request whose size is wider than eight bytes, or whose address is not aligned to its size, is consumed and answered with a one-cycle error pulse on its lane. It is never sent to the cache. Grants leave through registered lanes, one lane per port.

Top module: `dcp_pair_arb`

## Requirements
- R1: Two valid, well-formed reads (in_wr=0) are both accepted in the same cycle whatever their addresses.
- R2: Two valid, well-formed 8-byte writes (size code 3) are both accepted only when the address bits above bit 3 (addr[ADDR_W-1:4]) are equal.
- R3: Two valid, well-formed writes of size code 0, 1 or 2 are both accepted only when addr[ADDR_W-1:3] are equal and their byte masks do not overlap. A byte mask covers 2^size bytes starting at byte addr[2:0] of the 8-byte block.
- R4: A read paired with a write is accepted together only when addr[ADDR_W-1:4] are equal. An 8-byte write paired with a narrower write is never accepted together.
- R5: When both ports hold well-formed requests that may not pair, only the older port sees in_ready=1. Port 0 is older unless port 1 was stalled in the previous cycle.
- R6: A port stalled in one cycle is the older port in the next cycle, so a request it keeps presenting is accepted then.
- R7: A valid request with size code 4 to 7, or with addr not a multiple of 2^size, is accepted. One cycle later its lane shows out_err=1 and out_valid=0.
- R8: An accepted well-formed request on port i shows on lane i one cycle later with out_valid=1 and the same addr, size and write flag. Otherwise out_valid[i] is 0 in that cycle.
- R9: While rst_n is low, out_valid and out_err are 0 and port 0 is the older port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Request valid, one bit per port |
| in_ready | output | 2 | Request accepted this cycle, one bit per port |
| in_addr | input | 2 x ADDR_W | Byte address per port |
| in_size | input | 2 x 3 | Size code: bytes = 2^code for codes 0..3, codes 4..7 are illegal |
| in_wr | input | 2 | 1 = write, 0 = read |
| out_valid | output | 2 | Registered grant per lane |
| out_addr | output | 2 x ADDR_W | Address of the granted request |
| out_size | output | 2 x 3 | Size code of the granted request |
| out_wr | output | 2 | Write flag of the granted request |
| out_err | output | 2 | Registered reject pulse per lane |

## Verification
The embedded properties check several rules on every cycle. A stalled port must be accepted on the next cycle. A rejected request never also appears as a grant. Two well-formed reads are never split. Any pair that leaves together on both lanes must satisfy the block-sharing rule for its kind. The random and directed scenarios are needed for the rest. They show that refused pairs stall the correct port, that byte-overlap and mixed-width write cases are refused, and that the granted address, size and flag reach the right lane intact.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
   localparam int NUM_PORTS = 2;
   localparam int SIZE_W    = 3;
   localparam int QW_BYTES  = 8;
   localparam logic [SIZE_W-1:0] SZ_QUAD = 3'd3;

   typedef logic [QW_BYTES-1:0] bmask_t;

   function automatic bmask_t span_of(input logic [SIZE_W-1:0] sz);
      case (sz)
         3'd0:    span_of = 8'h01;
         3'd1:    span_of = 8'h03;
         3'd2:    span_of = 8'h0F;
         default: span_of = 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/dcp_req_check.sv
module dcp_req_check
   import dcp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              good,
   output logic              bad,
   output bmask_t            bytes
);
   logic misalign;
   logic oversize;

   always_comb begin
      oversize = (size > SZ_QUAD);
      case (size)
         3'd1:    misalign = addr[0];
         3'd2:    misalign = |addr[1:0];
         3'd3:    misalign = |addr[2:0];
         default: misalign = 1'b0;
      endcase
      bad   = valid & (oversize | misalign);
      good  = valid & ~(oversize | misalign);
      bytes = span_of(size) << addr[2:0];
   end
endmodule

// File: rtl/dcp_pair_rules.sv
module dcp_pair_rules
   import dcp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [SIZE_W-1:0] size_a,
   input  logic [SIZE_W-1:0] size_b,
   input  logic              wr_a,
   input  logic              wr_b,
   input  bmask_t            bytes_a,
   input  bmask_t            bytes_b,
   output logic              pair_ok
);
   logic same_ow, same_qw, quad_a, quad_b, disjoint;

   always_comb begin
      same_ow  = (addr_a[ADDR_W-1:4] == addr_b[ADDR_W-1:4]);
      same_qw  = (addr_a[ADDR_W-1:3] == addr_b[ADDR_W-1:3]);
      quad_a   = (size_a == SZ_QUAD);
      quad_b   = (size_b == SZ_QUAD);
      disjoint = ((bytes_a & bytes_b) == '0);
      if (!wr_a && !wr_b)
         pair_ok = 1'b1;
      else if (wr_a && wr_b) begin
         if (quad_a && quad_b)
            pair_ok = same_ow;
         else if (!quad_a && !quad_b)
            pair_ok = same_qw & disjoint;
         else
            pair_ok = 1'b0;
      end else
         pair_ok = same_ow;
   end
endmodule

// File: rtl/dcp_grant_regs.sv
module dcp_grant_regs
   import dcp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_PORTS-1:0]                 take,
   input  logic [NUM_PORTS-1:0]                 reject,
   input  logic                                 conflict,
   input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     addr,
   input  logic [NUM_PORTS-1:0][SIZE_W-1:0]     size,
   input  logic [NUM_PORTS-1:0]                 wr,
   output logic                                 second_older,
   output logic [NUM_PORTS-1:0]                 out_valid,
   output logic [NUM_PORTS-1:0][ADDR_W-1:0]     out_addr,
   output logic [NUM_PORTS-1:0][SIZE_W-1:0]     out_size,
   output logic [NUM_PORTS-1:0]                 out_wr,
   output logic [NUM_PORTS-1:0]                 out_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         second_older <= 1'b0;
      else
         second_older <= conflict ? ~second_older : 1'b0;
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid[p] <= 1'b0;
            out_err[p]   <= 1'b0;
            out_addr[p]  <= '0;
            out_size[p]  <= '0;
            out_wr[p]    <= 1'b0;
         end else begin
            out_valid[p] <= take[p];
            out_err[p]   <= reject[p];
            if (take[p]) begin
               out_addr[p] <= addr[p];
               out_size[p] <= size[p];
               out_wr[p]   <= wr[p];
            end
         end
      end

      // R7
      err_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_err[p] |-> !out_valid[p]);
   end
endmodule

// File: rtl/dcp_pair_arb.sv
module dcp_pair_arb
   import dcp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [1:0]                       in_valid,
   output logic [1:0]                       in_ready,
   input  logic [1:0][ADDR_W-1:0]           in_addr,
   input  logic [1:0][2:0]                  in_size,
   input  logic [1:0]                       in_wr,
   output logic [1:0]                       out_valid,
   output logic [1:0][ADDR_W-1:0]           out_addr,
   output logic [1:0][2:0]                  out_size,
   output logic [1:0]                       out_wr,
   output logic [1:0]                       out_err
);
   if (ADDR_W < 4) begin : g_addr_w_chk
      $error("dcp_pair_arb: ADDR_W must be at least 4");
   end
   if (NUM_PORTS != 2 || SIZE_W != 3) begin : g_shape_chk
      $error("dcp_pair_arb: package shape does not match the port list");
   end

   logic [NUM_PORTS-1:0] good, bad, take;
   bmask_t               bytes [NUM_PORTS];
   logic                 pair_ok, conflict, second_older;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      dcp_req_check #(.ADDR_W(ADDR_W)) chk_i (
         .valid (in_valid[p]),
         .addr  (in_addr[p]),
         .size  (in_size[p]),
         .good  (good[p]),
         .bad   (bad[p]),
         .bytes (bytes[p])
      );
   end

   dcp_pair_rules #(.ADDR_W(ADDR_W)) rules_i (
      .addr_a  (in_addr[0]),
      .addr_b  (in_addr[1]),
      .size_a  (in_size[0]),
      .size_b  (in_size[1]),
      .wr_a    (in_wr[0]),
      .wr_b    (in_wr[1]),
      .bytes_a (bytes[0]),
      .bytes_b (bytes[1]),
      .pair_ok (pair_ok)
   );

   always_comb begin
      conflict    = good[0] & good[1] & ~pair_ok;
      in_ready[0] = ~(conflict & second_older);
      in_ready[1] = ~(conflict & ~second_older);
      take        = good & in_ready;
   end

   dcp_grant_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (take),
      .reject       (bad),
      .conflict     (conflict),
      .addr         (in_addr),
      .size         (in_size),
      .wr           (in_wr),
      .second_older (second_older),
      .out_valid    (out_valid),
      .out_addr     (out_addr),
      .out_size     (out_size),
      .out_wr       (out_wr),
      .out_err      (out_err)
   );

   // R1
   read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (good == 2'b11 && in_wr == 2'b00) |-> (in_ready == 2'b11));

   // R6
   held_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[0] && !in_ready[0]) |=> (in_ready[0] || !in_valid[0]));

   // R6
   held_port1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[1] && !in_ready[1]) |=> (in_ready[1] || !in_valid[1]));

   // R2 R4
   paired_write_ow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == 2'b11 && (out_wr != 2'b00) &&
       !(out_wr == 2'b11 && out_size[0] != 3'd3))
      |-> (out_addr[0][ADDR_W-1:4] == out_addr[1][ADDR_W-1:4]));

   // R5
   one_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready != 2'b00);
endmodule

// File: tb/dcp_pair_arb_tb.sv
module dcp_pair_arb_tb_top;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]         in_valid = '0;
   logic [1:0]         in_ready;
   logic [1:0][AW-1:0] in_addr = '0;
   logic [1:0][2:0]    in_size = '0;
   logic [1:0]         in_wr = '0;
   logic [1:0]         out_valid;
   logic [1:0][AW-1:0] out_addr;
   logic [1:0][2:0]    out_size;
   logic [1:0]         out_wr;
   logic [1:0]         out_err;

   int n_chk = 0;
   int n_err = 0;
   logic m_old1 = 1'b0;
   logic [1:0] pend_vld = '0, pend_err = '0, held = '0;
   logic [1:0][AW-1:0] pend_addr;
   logic [1:0][2:0]    pend_size;
   logic [1:0]         pend_wr;
   logic done = 1'b0;

   always #2 clk = ~clk;

   dcp_pair_arb #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .in_size(in_size), .in_wr(in_wr),
      .out_valid(out_valid), .out_addr(out_addr), .out_size(out_size),
      .out_wr(out_wr), .out_err(out_err)
   );

   function automatic logic f_bad(input logic [AW-1:0] a, input logic [2:0] s);
      if (s > 3'd3) return 1'b1;
      return (a & ((AW'(1) << s) - AW'(1))) != '0;
   endfunction

   function automatic logic [7:0] f_mask(input logic [AW-1:0] a, input logic [2:0] s);
      logic [7:0] m;
      m = 8'((9'd1 << (4'd1 << s)) - 9'd1);
      return m << a[2:0];
   endfunction

   function automatic logic f_legal(input logic [AW-1:0] a0, input logic [2:0] s0, input logic w0,
                                    input logic [AW-1:0] a1, input logic [2:0] s1, input logic w1);
      if (!w0 && !w1) return 1'b1;
      if (w0 != w1) return a0[AW-1:4] == a1[AW-1:4];
      if (s0 == 3'd3 && s1 == 3'd3) return a0[AW-1:4] == a1[AW-1:4];
      if (s0 != 3'd3 && s1 != 3'd3)
         return (a0[AW-1:3] == a1[AW-1:3]) && ((f_mask(a0, s0) & f_mask(a1, s1)) == 8'h00);
      return 1'b0;
   endfunction

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_pending();
      for (int p = 0; p < 2; p++) begin
         chk(out_valid[p] == pend_vld[p], "R8 out_valid", out_valid[p], pend_vld[p]);
         chk(out_err[p] == pend_err[p], "R7 out_err", out_err[p], pend_err[p]);
         if (pend_vld[p] && out_valid[p]) begin
            chk(out_addr[p] == pend_addr[p], "R8 out_addr", out_addr[p], pend_addr[p]);
            chk(out_size[p] == pend_size[p], "R8 out_size", out_size[p], pend_size[p]);
            chk(out_wr[p] == pend_wr[p], "R8 out_wr", out_wr[p], pend_wr[p]);
         end
      end
   endtask

   task automatic step(input string tag,
                       input logic v0, input logic [AW-1:0] a0, input logic [2:0] s0, input logic w0,
                       input logic v1, input logic [AW-1:0] a1, input logic [2:0] s1, input logic w1);
      logic [1:0] gd, bd, er;
      logic cf;
      @(negedge clk);
      check_pending();
      in_valid = {v1, v0};
      in_addr  = {a1, a0};
      in_size  = {s1, s0};
      in_wr    = {w1, w0};
      #1;
      bd[0] = v0 & f_bad(a0, s0);
      bd[1] = v1 & f_bad(a1, s1);
      gd[0] = v0 & ~bd[0];
      gd[1] = v1 & ~bd[1];
      cf = gd[0] & gd[1] & ~f_legal(a0, s0, w0, a1, s1, w1);
      er[0] = ~(cf & m_old1);
      er[1] = ~(cf & ~m_old1);
      chk(in_ready == er, tag, in_ready, er);
      pend_vld  = gd & er;
      pend_err  = bd;
      pend_addr = {a1, a0};
      pend_size = {s1, s0};
      pend_wr   = {w1, w0};
      held      = {v1, v0} & ~er;
      m_old1    = cf ? ~m_old1 : 1'b0;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [1:0] rv, rw;
      logic [1:0][AW-1:0] ra;
      logic [1:0][2:0] rs;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(out_valid == 2'b00, "R9 out_valid", out_valid, 0);
      chk(out_err == 2'b00, "R9 out_err", out_err, 0);
      rst_n = 1'b1;

      // R1: reads far apart pair
      step("R1 read pair", 1, 16'h0100, 3, 0, 1, 16'h8008, 3, 0);
      step("R1 mixed size reads", 1, 16'h0203, 0, 0, 1, 16'h7F04, 2, 0);
      // R2: quad writes
      step("R2 same octaword", 1, 16'h0040, 3, 1, 1, 16'h0048, 3, 1);
      step("R2 split octaword", 1, 16'h0040, 3, 1, 1, 16'h0050, 3, 1);
      // R6: port1 held, now older; port0 new conflicting
      step("R6 held port1 wins", 1, 16'h0060, 3, 1, 1, 16'h0050, 3, 1);
      step("R6 held port0 wins", 1, 16'h0060, 3, 1, 0, 16'h0000, 0, 0);
      // R3: narrow writes
      step("R3 disjoint bytes", 1, 16'h0020, 2, 1, 1, 16'h0024, 2, 1);
      step("R3 overlap bytes", 1, 16'h0020, 2, 1, 1, 16'h0022, 1, 1);
      step("R5 retry stalled", 0, 16'h0000, 0, 0, 1, 16'h0022, 1, 1);
      step("R3 other quadword", 1, 16'h0020, 0, 1, 1, 16'h0028, 0, 1);
      step("R5 retry stalled", 0, 16'h0000, 0, 0, 1, 16'h0028, 0, 1);
      // R4: read with write
      step("R4 rd/wr same octaword", 1, 16'h0030, 3, 0, 1, 16'h0038, 3, 1);
      step("R4 rd/wr split", 1, 16'h0030, 3, 0, 1, 16'h0040, 3, 1);
      step("R5 retry stalled", 0, 16'h0000, 0, 0, 1, 16'h0040, 3, 1);
      step("R4 quad+byte write", 1, 16'h0030, 3, 1, 1, 16'h0039, 0, 1);
      step("R5 retry stalled", 0, 16'h0000, 0, 0, 1, 16'h0039, 0, 1);
      // R7: rejects
      step("R7 oversize", 1, 16'h0000, 4, 0, 1, 16'h0031, 1, 1);
      step("R7 misaligned quad", 1, 16'h0044, 3, 1, 1, 16'h0040, 7, 0);

      // R5: random mix, held requests kept stable
      rv = '0; ra = '0; rs = '0; rw = '0;
      for (int i = 0; i < 3000; i++) begin
         for (int p = 0; p < 2; p++) begin
            if (!held[p]) begin
               rv[p] = ($urandom % 5) != 0;
               rs[p] = (($urandom % 10) == 9) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
               ra[p] = {10'h000, 2'($urandom), 4'($urandom)};
               if (($urandom % 4) != 0 && rs[p] < 3'd4)
                  ra[p] = ra[p] & ~((AW'(1) << rs[p]) - AW'(1));
               rw[p] = $urandom % 2;
            end
         end
         step("R5 random", rv[0], ra[0], rs[0], rw[0], rv[1], ra[1], rs[1], rw[1]);
      end
      step("R8 drain", 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      check_pending();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule